// File: doc/BRIEF.md
# Serial Multiple-of-Five Checker

This block watches a binary number that arrives one bit per clock, most significant bit first, and says after every bit whether the value received so far is an exact multiple of five. The number may be arbitrarily long. The block never stores it. Appending a bit b to a value N gives 2N + b, so the block only needs to carry the remainder of N divided by five from one bit to the next.

A bit is presented together with a valid strobe. In the same cycle the block raises a combinational flag if that bit brings the remainder to zero. One cycle later it also gives a registered copy of the flag, which downstream logic can use without a combinational path through the block. Cycles in which the strobe is low leave the remainder untouched. An asynchronous active-low reset is released in step with the clock and clears the remainder.

Top module: `mod5_stream_checker`

## Requirements
- R1: While reset is applied and after it is released, both flags are low and the remainder is zero. As a result, a first valid bit of 0 after reset raises the combinational flag.
- R2: On a cycle with the valid strobe high, the combinational flag `div_now_o` is 1 exactly when the value formed by all valid bits since reset is a multiple of five. Bits are taken most significant first, so each bit b turns value N into 2N + b.
- R3: The remainder is held in 3 bits as codes 0 to 4. A valid bit b moves remainder r to (2r + b) mod 5. Codes 5 to 7 are not reachable; on the next valid bit they move to remainder 0 with the flag low.
- R4: The flag is a Mealy output. It rises in the same cycle as the valid bit that brings the remainder to zero, before the clock edge, and it depends on both that bit and the current remainder.
- R5: In a cycle with the valid strobe low, the remainder holds and `div_now_o` is low.
- R6: `div_reg_o` equals the value `div_now_o` had in the previous clock cycle.
- R7: There is no limit on the stream length. Results stay exact for streams of several hundred bits with idle cycles mixed in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| bit_vld_i | input | 1 | High when `bit_i` carries the next bit of the number |
| bit_i | input | 1 | Serial data bit, most significant first |
| div_now_o | output | 1 | Combinational flag: the value including this bit is a multiple of five |
| div_reg_o | output | 1 | Copy of `div_now_o` delayed by one clock |

## Verification
The embedded properties check the following on every cycle:
- The remainder register never leaves codes 0 to 4.
- The remainder holds and the flag stays low when no bit is offered.
- A raised flag is always followed by a zero remainder.
- A zero bit arriving on remainder zero always raises the flag.
- The registered flag only follows a cycle that carried a valid bit.

The bench scenarios show the arithmetic correctness of the flag against wide integer values, the full transition table from each reachable remainder, the reset state, and exactness over long streams with gaps. The one-cycle lag of the registered copy is also shown only by the scenarios. Recovery from codes 5 to 7 cannot be reached from the ports and is guarded by the legality property alone.

// File: rtl/mod5_pkg.sv
package mod5_pkg;

  localparam int unsigned MODULUS = 5;
  localparam int unsigned REM_W   = $clog2(MODULUS);

  typedef logic [REM_W-1:0] rem_t;

  localparam rem_t REM_ZERO = '0;

endpackage

// File: rtl/mod5_rst_sync.sv
module mod5_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/mod5_rem_step.sv
module mod5_rem_step
  import mod5_pkg::*;
(
  input  rem_t rem_q_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output rem_t rem_d_o,
  output logic hit_o
);

  localparam logic [REM_W:0] MOD_EXT = (REM_W + 1)'(MODULUS);

  logic            legal;
  logic [REM_W:0]  doubled;
  logic [REM_W:0]  reduced;

  assign legal = ({1'b0, rem_q_i} < MOD_EXT);

  always_comb begin
    doubled = {rem_q_i, bit_i};
    if (doubled >= MOD_EXT) begin
      reduced = doubled - MOD_EXT;
    end else begin
      reduced = doubled;
    end
  end

  always_comb begin
    rem_d_o = rem_q_i;
    hit_o   = 1'b0;
    if (bit_vld_i) begin
      if (legal) begin
        rem_d_o = reduced[REM_W-1:0];
        hit_o   = (reduced == '0);
      end else begin
        rem_d_o = REM_ZERO;
        hit_o   = 1'b0;
      end
    end
  end

endmodule

// File: rtl/mod5_rem_reg.sv
module mod5_rem_reg
  import mod5_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  rem_t rem_d_i,
  output rem_t rem_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q_o <= REM_ZERO;
    end else if (load_i) begin
      rem_q_o <= rem_d_i;
    end
  end

  // R3
  rem_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q_o < rem_t'(MODULUS));

  // R5
  rem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(rem_q_o));

endmodule

// File: rtl/mod5_flag_reg.sv
module mod5_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_d_i,
  output logic flag_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q_o <= 1'b0;
    end else begin
      flag_q_o <= flag_d_i;
    end
  end

endmodule

// File: rtl/mod5_stream_checker.sv
module mod5_stream_checker
  import mod5_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic div_now_o,
  output logic div_reg_o
);

  logic rst_n_int;
  rem_t rem_q;
  rem_t rem_d;
  logic hit;

  mod5_rst_sync #(
    .STAGES (RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  mod5_rem_step u_step (
    .rem_q_i   (rem_q),
    .bit_vld_i (bit_vld_i),
    .bit_i     (bit_i),
    .rem_d_o   (rem_d),
    .hit_o     (hit)
  );

  mod5_rem_reg u_rem (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .load_i  (bit_vld_i),
    .rem_d_i (rem_d),
    .rem_q_o (rem_q)
  );

  mod5_flag_reg u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .flag_d_i (hit),
    .flag_q_o (div_reg_o)
  );

  assign div_now_o = hit;

  // R5
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !bit_vld_i |-> !div_now_o);

  // R4
  land_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    div_now_o |=> (rem_q == REM_ZERO));

  // R2
  zero_on_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (bit_vld_i && !bit_i && rem_q == REM_ZERO) |-> div_now_o);

  // R6
  reg_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    div_reg_o |-> $past(bit_vld_i));

endmodule

// File: tb/mod5_stream_checker_test.sv
`timescale 1ns/1ps
module mod5_stream_checker_test;

  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rst_ni;
  logic bit_vld;
  logic bit_in;
  logic div_now_o;
  logic div_reg_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [255:0] ref_val;

  always #(HALF) clk = ~clk;

  mod5_stream_checker uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld),
    .bit_i     (bit_in),
    .div_now_o (div_now_o),
    .div_reg_o (div_reg_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    bit_vld = 1'b0;
    bit_in  = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 flag during reset", div_now_o, 1'b0);
    check("R1 registered flag during reset", div_reg_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    ref_val = '0;
    #1;
    check("R1 registered flag after release", div_reg_o, 1'b0);
  endtask

  task automatic step(input logic vld, input logic b, input string tag);
    logic exp;
    @(negedge clk);
    bit_vld = vld;
    bit_in  = b;
    if (vld) ref_val = {ref_val[254:0], b};
    exp = vld && ((ref_val % 256'd5) == 256'd0);
    #1;
    check(tag, div_now_o, exp);
    @(posedge clk);
    #1;
    check("R6 registered copy", div_reg_o, exp);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: zero remainder after reset, first bit 0 gives value 0
    step(1'b1, 1'b0, "R1 first zero bit");
    step(1'b1, 1'b1, "R2 value 1");

    // R4: 1,0,1 -> 5 flagged in the same cycle as the last bit
    do_reset();
    step(1'b1, 1'b1, "R4 prefix");
    step(1'b1, 1'b0, "R4 prefix");
    step(1'b1, 1'b1, "R4 lands on five");
    // R5: idle cycles keep value 5, flag low
    step(1'b0, 1'b1, "R5 idle");
    step(1'b0, 1'b0, "R5 idle");
    step(1'b1, 1'b0, "R5 value held then 10");
    step(1'b1, 1'b1, "R2 value 21");

    // R3: every reachable remainder with both input bits
    for (int r = 0; r < 5; r++) begin
      for (int b = 0; b < 2; b++) begin
        logic [2:0] rv;
        rv = 3'(r);
        do_reset();
        for (int k = 2; k >= 0; k--) step(1'b1, rv[k], "R2 prefix");
        step(1'b1, 1'(b), "R3 table step");
        step(1'b1, 1'b0, "R3 follow step");
      end
    end

    // R7: long random streams with gaps
    for (int s = 0; s < 3; s++) begin
      do_reset();
      for (int i = 0; i < 240; i++) begin
        logic v;
        v = (($urandom % 5) != 0);
        step(v, 1'($urandom % 2), v ? "R7 long stream" : "R5 idle gap");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule